// File: doc/BRIEF.md
# Multi-Level Address Translation Walker

This block is a hardware table walker for a paged, multi-level translation scheme. It takes one request at a time and turns a virtual address into a real address. A request carries the virtual address, an access kind (read, write or instruction fetch), an address-space mode, a translation-enable flag and a 64-bit-mode flag. Three root descriptors, one for each address space, and a prefix value are sampled with it. When translation is on, the walker picks a root descriptor and checks the address against the range allowed by the root's type. It then reads between one and five table entries through a 64-bit read port, ending at a page-table entry.

The result is either a real address with read/write/execute permissions or a fault. A fault comes with a code and an exception word that holds the address and the space that was used. The result is presented for a single cycle with a `done` pulse. Real addresses in the low 8 KiB window are relocated by the prefix value. In secondary mode, instruction fetches and data accesses go through different roots.

Encodings used throughout: access kind 0 = read, 1 = write, 2 = fetch. Mode 1 = primary, 2 = secondary, 3 = home. Permission bits [2] = read, [1] = write, [0] = execute. Fault code 0 = none, 1 = page-translation, 2 = segment-translation, 3 = translation-specification, 4 = protection. A region or segment descriptor holds a table origin in bits 63:12, a real-space flag in bit 6, an invalid flag in bit 5 and a type in bits 3:2. The type values are 3 = region-first, 2 = region-second, 1 = region-third, 0 = segment. A page-table entry holds a frame in bits 63:12, an invalid flag in bit 10 and a read-only flag in bit 9.

Top module: `xlat_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. It drops in the cycle after a request is accepted and returns in the cycle after `done`. `done` lasts one cycle, and the result outputs are valid in that cycle.
- R2: With translation disabled, the real address is the virtual address with bits 11:0 cleared, the permissions are 3'b111, and no memory read is issued.
- R3: With 64-bit mode off, the virtual address is reduced to its bits 30:0 before any other step, including the range check and the exception word.
- R4: Mode 1 walks from `root_pri` and mode 3 walks from `root_home`. In mode 2, data accesses walk from `root_sec`.
- R5: A root of type region-second, region-third or segment requires virtual-address bits 63:53, 63:42 or 63:31 respectively to be zero. Otherwise the result is fault 3, with no memory read.
- R6: Each table read is 8 bytes at the origin plus an index. The index is va[63:53]*8 for a region-first table, va[52:42]*8 for region-second, va[41:31]*8 for region-third, va[30:20]*8 for a segment table and va[19:12]*8 for a page table. The walk starts at the table named by the root's type.
- R7: An invalid flag in the root or in any region or segment entry ends the walk with fault 2.
- R8: An entry read from a region table must carry the type one below that table's type. A mismatch ends the walk with fault 3.
- R9: A root with its real-space flag set ends the walk with the virtual address as the real address, without memory reads.
- R10: A page-table entry with its invalid flag gives fault 1. A valid page-table entry gives its bits 63:12 as the real address.
- R11: A read-only page-table entry removes write permission. A write access to such a page gives fault 4.
- R12: In mode 2, a fetch walks from `root_pri`, keeps only execute permission and reports space 1. A data access loses execute permission.
- R13: A real address below 0x2000 has `prefix` added to it. Addresses from 0x2000 upward are returned unchanged.
- R14: On a fault, the permissions and real address are zero. The exception word is the virtual address ORed with the space code (1, 2 or 3), plus 4 for a protection fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 64 | Virtual address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_mode | input | 2 | Address-space mode: 1 primary, 2 secondary, 3 home |
| req_dat_en | input | 1 | Translation enabled |
| req_wide | input | 1 | 64-bit addressing mode |
| root_pri | input | 64 | Primary root descriptor |
| root_sec | input | 64 | Secondary root descriptor |
| root_home | input | 64 | Home root descriptor |
| prefix | input | 64 | Relocation base for the low window |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 64 | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry contents |
| done | output | 1 | One-cycle result strobe |
| rsp_raddr | output | 64 | Absolute real address |
| rsp_perm | output | 3 | Permissions {read, write, execute} |
| rsp_fault | output | 3 | Fault code |
| rsp_xword | output | 64 | Translation-exception word |

## Verification
The assertions assume that memory returns exactly one response for each accepted read and never responds unasked. They also assume that `req_mode` is never 0 and `req_kind` is never 3. The bench memory model keeps to the first two assumptions: it answers one cycle after each handshake and withholds `mem_rd_ready` on every third cycle to exercise the request hold. The directed tasks drive only the legal mode and kind codes. They place every table entry at an address the bench computes from the index formulas, and count reads that hit an unprogrammed address.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2
   } acc_kind_e;

   typedef enum logic [2:0] {
      FLT_NONE    = 3'd0,
      FLT_PAGE    = 3'd1,
      FLT_SEGMENT = 3'd2,
      FLT_SPEC    = 3'd3,
      FLT_PROT    = 3'd4
   } fault_e;

   localparam logic [1:0] SPACE_PRI  = 2'd1;
   localparam logic [1:0] SPACE_SEC  = 2'd2;
   localparam logic [1:0] SPACE_HOME = 2'd3;

   localparam int unsigned DESC_TYPE_LO  = 2;
   localparam int unsigned DESC_TYPE_W   = 2;
   localparam int unsigned DESC_INV_BIT  = 5;
   localparam int unsigned DESC_REAL_BIT = 6;
   localparam int unsigned PTE_RO_BIT    = 9;
   localparam int unsigned PTE_INV_BIT   = 10;

   localparam logic [2:0] PERM_R    = 3'b100;
   localparam logic [2:0] PERM_W    = 3'b010;
   localparam logic [2:0] PERM_X    = 3'b001;
   localparam logic [2:0] PERM_ALL  = 3'b111;
   localparam logic [2:0] PERM_NONE = 3'b000;

endpackage

// File: rtl/xlat_space_sel.sv
module xlat_space_sel
   import xlat_pkg::*;
#(
   parameter int unsigned DW = 64
) (
   input  logic [1:0]    mode,
   input  logic [1:0]    kind,
   input  logic [DW-1:0] root_pri,
   input  logic [DW-1:0] root_sec,
   input  logic [DW-1:0] root_home,
   output logic [DW-1:0] root,
   output logic [1:0]    space,
   output logic [2:0]    perm_mask
);

   always_comb begin
      root      = root_pri;
      space     = SPACE_PRI;
      perm_mask = PERM_ALL;
      case (mode)
         SPACE_SEC: begin
            if (acc_kind_e'(kind) == ACC_FETCH) begin
               root      = root_pri;
               space     = SPACE_PRI;
               perm_mask = PERM_X;
            end else begin
               root      = root_sec;
               space     = SPACE_SEC;
               perm_mask = PERM_R | PERM_W;
            end
         end
         SPACE_HOME: begin
            root  = root_home;
            space = SPACE_HOME;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/xlat_index_gen.sv
module xlat_index_gen #(
   parameter int unsigned VA_W       = 64,
   parameter int unsigned PAGE_SHIFT = 12,
   parameter int unsigned PT_IDX_W   = 8,
   parameter int unsigned RGN_IDX_W  = 11,
   parameter int unsigned ENTRY_LOG  = 3,
   parameter int unsigned LEVELS     = 5,
   localparam int unsigned LVL_W     = $clog2(LEVELS),
   localparam int unsigned TYPE_W    = $clog2(LEVELS - 1)
) (
   input  logic [VA_W-1:0]   va,
   input  logic [LVL_W-1:0]  lvl,
   input  logic [TYPE_W-1:0] root_type,
   output logic [VA_W-1:0]   offset,
   output logic              range_ok
);

   logic [VA_W-1:0]   off_arr [LEVELS];
   logic [LEVELS-2:0] ok_vec;

   if (PAGE_SHIFT + PT_IDX_W + RGN_IDX_W * (LEVELS - 1) != VA_W) begin : g_bad_tiling
      $error("xlat_index_gen: index fields must tile the virtual address");
   end

   for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      localparam int unsigned LO = (l == 0) ? PAGE_SHIFT
                                            : PAGE_SHIFT + PT_IDX_W + RGN_IDX_W * (l - 1);
      localparam int unsigned W  = (l == 0) ? PT_IDX_W : RGN_IDX_W;
      assign off_arr[l] = VA_W'(va[LO +: W]) << ENTRY_LOG;
   end

   for (genvar t = 0; t < LEVELS - 1; t++) begin : g_rng
      localparam int unsigned TOP = PAGE_SHIFT + PT_IDX_W + RGN_IDX_W * (t + 1);
      if (TOP >= VA_W) begin : g_full
         assign ok_vec[t] = 1'b1;
      end else begin : g_chk
         assign ok_vec[t] = (va[VA_W-1:TOP] == '0);
      end
   end

   assign offset   = (lvl < LVL_W'(LEVELS)) ? off_arr[lvl] : '0;
   assign range_ok = ok_vec[root_type];

   logic unused_low;
   assign unused_low = ^va[PAGE_SHIFT-1:0];

endmodule

// File: rtl/xlat_prefix_reloc.sv
module xlat_prefix_reloc #(
   parameter int unsigned     AW        = 64,
   parameter logic [AW-1:0]   LOW_LIMIT = AW'(64'h2000)
) (
   input  logic [AW-1:0] raddr,
   input  logic [AW-1:0] prefix,
   output logic [AW-1:0] aaddr
);

   assign aaddr = (raddr < LOW_LIMIT) ? raddr + prefix : raddr;

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
   import xlat_pkg::*;
#(
   parameter int unsigned VA_W       = 64,
   parameter int unsigned PAGE_SHIFT = 12,
   parameter int unsigned PT_IDX_W   = 8,
   parameter int unsigned RGN_IDX_W  = 11,
   parameter int unsigned NARROW_W   = 31,
   parameter logic [63:0] LOW_LIMIT  = 64'h2000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [VA_W-1:0] req_va,
   input  logic [1:0]      req_kind,
   input  logic [1:0]      req_mode,
   input  logic            req_dat_en,
   input  logic            req_wide,
   input  logic [VA_W-1:0] root_pri,
   input  logic [VA_W-1:0] root_sec,
   input  logic [VA_W-1:0] root_home,
   input  logic [VA_W-1:0] prefix,
   output logic            mem_rd_valid,
   input  logic            mem_rd_ready,
   output logic [VA_W-1:0] mem_rd_addr,
   input  logic            mem_rsp_valid,
   input  logic [VA_W-1:0] mem_rsp_data,
   output logic            done,
   output logic [VA_W-1:0] rsp_raddr,
   output logic [2:0]      rsp_perm,
   output logic [2:0]      rsp_fault,
   output logic [VA_W-1:0] rsp_xword
);

   localparam int unsigned LEVELS = 1 + (VA_W - PAGE_SHIFT - PT_IDX_W) / RGN_IDX_W;
   localparam int unsigned LVL_W  = $clog2(LEVELS);
   localparam logic [VA_W-1:0] NARROW_MASK = (VA_W'(1) << NARROW_W) - VA_W'(1);

   if (LEVELS - 1 != (1 << DESC_TYPE_W)) begin : g_bad_levels
      $error("xlat_walker: table levels must match the descriptor type field");
   end
   if (NARROW_W >= VA_W || PAGE_SHIFT <= PTE_INV_BIT) begin : g_bad_widths
      $error("xlat_walker: narrow width or page size out of range");
   end

   typedef enum logic [2:0] {ST_IDLE, ST_CHECK, ST_ISSUE, ST_WAIT, ST_DONE} st_e;

   st_e              st_q;
   logic [VA_W-1:0]  va_q, root_q, prefix_q, origin_q, addr_q;
   acc_kind_e        kind_q;
   logic [1:0]       space_q;
   logic [2:0]       pmask_q, perm_q;
   logic             dat_q;
   logic [LVL_W-1:0] lvl_q;
   fault_e           fault_q;

   logic [VA_W-1:0]        va_in, sel_root, tbl_off, reloc_addr, rsp_frame;
   logic [1:0]             sel_space;
   logic [2:0]             sel_pmask;
   logic                   range_ok, pte_ro;
   logic [DESC_TYPE_W-1:0] root_type, entry_type;

   always_comb begin
      va_in = req_wide ? req_va : (req_va & NARROW_MASK);
      va_in[PAGE_SHIFT-1:0] = '0;
   end

   xlat_space_sel #(.DW(VA_W)) space_sel_i (
      .mode      (req_mode),
      .kind      (req_kind),
      .root_pri  (root_pri),
      .root_sec  (root_sec),
      .root_home (root_home),
      .root      (sel_root),
      .space     (sel_space),
      .perm_mask (sel_pmask)
   );

   assign root_type  = root_q[DESC_TYPE_LO +: DESC_TYPE_W];
   assign entry_type = mem_rsp_data[DESC_TYPE_LO +: DESC_TYPE_W];
   assign rsp_frame  = {mem_rsp_data[VA_W-1:PAGE_SHIFT], PAGE_SHIFT'(0)};
   assign pte_ro     = mem_rsp_data[PTE_RO_BIT];

   xlat_index_gen #(
      .VA_W       (VA_W),
      .PAGE_SHIFT (PAGE_SHIFT),
      .PT_IDX_W   (PT_IDX_W),
      .RGN_IDX_W  (RGN_IDX_W),
      .ENTRY_LOG  (3),
      .LEVELS     (LEVELS)
   ) index_gen_i (
      .va        (va_q),
      .lvl       (lvl_q),
      .root_type (root_type),
      .offset    (tbl_off),
      .range_ok  (range_ok)
   );

   xlat_prefix_reloc #(.AW(VA_W), .LOW_LIMIT(VA_W'(LOW_LIMIT))) reloc_i (
      .raddr  (addr_q),
      .prefix (prefix_q),
      .aaddr  (reloc_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         va_q     <= '0;
         root_q   <= '0;
         prefix_q <= '0;
         origin_q <= '0;
         addr_q   <= '0;
         kind_q   <= ACC_READ;
         space_q  <= SPACE_PRI;
         pmask_q  <= PERM_ALL;
         perm_q   <= PERM_NONE;
         dat_q    <= 1'b0;
         lvl_q    <= '0;
         fault_q  <= FLT_NONE;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q     <= va_in;
                  root_q   <= sel_root;
                  prefix_q <= prefix;
                  kind_q   <= acc_kind_e'(req_kind);
                  space_q  <= sel_space;
                  pmask_q  <= sel_pmask;
                  dat_q    <= req_dat_en;
                  fault_q  <= FLT_NONE;
                  perm_q   <= PERM_NONE;
                  addr_q   <= '0;
                  st_q     <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               if (!dat_q) begin
                  addr_q <= va_q;
                  perm_q <= PERM_ALL;
                  st_q   <= ST_DONE;
               end else if (!range_ok) begin
                  fault_q <= FLT_SPEC;
                  st_q    <= ST_DONE;
               end else if (root_q[DESC_INV_BIT]) begin
                  fault_q <= FLT_SEGMENT;
                  st_q    <= ST_DONE;
               end else if (root_q[DESC_REAL_BIT]) begin
                  addr_q <= va_q;
                  perm_q <= pmask_q;
                  st_q   <= ST_DONE;
               end else begin
                  origin_q <= {root_q[VA_W-1:PAGE_SHIFT], PAGE_SHIFT'(0)};
                  lvl_q    <= LVL_W'(root_type) + LVL_W'(1);
                  st_q     <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (mem_rd_ready) st_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (mem_rsp_valid) begin
                  if (lvl_q != '0) begin
                     if (mem_rsp_data[DESC_INV_BIT]) begin
                        fault_q <= FLT_SEGMENT;
                        st_q    <= ST_DONE;
                     end else if (lvl_q >= LVL_W'(2) &&
                                  entry_type != DESC_TYPE_W'(lvl_q - LVL_W'(2))) begin
                        fault_q <= FLT_SPEC;
                        st_q    <= ST_DONE;
                     end else begin
                        origin_q <= rsp_frame;
                        lvl_q    <= lvl_q - LVL_W'(1);
                        st_q     <= ST_ISSUE;
                     end
                  end else begin
                     st_q <= ST_DONE;
                     if (mem_rsp_data[PTE_INV_BIT]) begin
                        fault_q <= FLT_PAGE;
                     end else if (pte_ro && kind_q == ACC_WRITE) begin
                        fault_q <= FLT_PROT;
                     end else begin
                        addr_q <= rsp_frame;
                        perm_q <= (pte_ro ? (PERM_R | PERM_X) : PERM_ALL) & pmask_q;
                     end
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready    = (st_q == ST_IDLE);
   assign mem_rd_valid = (st_q == ST_ISSUE);
   assign mem_rd_addr  = origin_q + tbl_off;
   assign done         = (st_q == ST_DONE);
   assign rsp_fault    = fault_q;
   assign rsp_perm     = perm_q;
   assign rsp_raddr    = (fault_q == FLT_NONE) ? reloc_addr : '0;
   assign rsp_xword    = (fault_q == FLT_NONE) ? '0
                        : (va_q | VA_W'({fault_q == FLT_PROT, space_q}));

   logic unused_bits;
   assign unused_bits = ^{root_q[DESC_TYPE_LO-1:0], root_q[4], root_q[PAGE_SHIFT-1:DESC_REAL_BIT+1],
                          mem_rsp_data[DESC_TYPE_LO-1:0], mem_rsp_data[4],
                          mem_rsp_data[PTE_RO_BIT-1:DESC_REAL_BIT],
                          mem_rsp_data[PAGE_SHIFT-1:PTE_INV_BIT+1]};

   // R1
   accept_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);

   // R1
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && req_ready);

   // R6
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

   // R6
   rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> mem_rd_addr[2:0] == 3'b000);

   // R11
   write_needs_w_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && rsp_fault == FLT_NONE && kind_q == ACC_WRITE |-> rsp_perm[1]);

   // R14
   fault_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && rsp_fault != FLT_NONE |-> rsp_perm == PERM_NONE && rsp_xword[1:0] != 2'b00);

endmodule

// File: tb/xlat_walker_tb_top.sv
`timescale 1ns/1ps
module xlat_walker_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [63:0] req_va = '0;
   logic [1:0]  req_kind = '0;
   logic [1:0]  req_mode = 2'd1;
   logic        req_dat_en = 1'b0;
   logic        req_wide = 1'b1;
   logic [63:0] root_pri = '0, root_sec = '0, root_home = '0;
   logic [63:0] prefix = 64'h40000;
   logic        mem_rd_valid;
   logic        mem_rd_ready = 1'b0;
   logic [63:0] mem_rd_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic        done;
   logic [63:0] rsp_raddr;
   logic [2:0]  rsp_perm;
   logic [2:0]  rsp_fault;
   logic [63:0] rsp_xword;

   always #2 clk = ~clk;

   xlat_walker dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
      .req_kind(req_kind), .req_mode(req_mode), .req_dat_en(req_dat_en),
      .req_wide(req_wide), .root_pri(root_pri), .root_sec(root_sec),
      .root_home(root_home), .prefix(prefix),
      .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
      .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .done(done), .rsp_raddr(rsp_raddr),
      .rsp_perm(rsp_perm), .rsp_fault(rsp_fault), .rsp_xword(rsp_xword)
   );

   int total = 0;
   int bad = 0;
   int rd_count = 0;
   int miss_count = 0;
   bit finished = 0;
   logic [63:0] mem [longint unsigned];

   logic [63:0] r_addr, r_xword;
   logic [2:0]  r_perm, r_fault;
   int          r_reads, r_miss;

   localparam logic [63:0] T1 = 64'h10000, T2 = 64'h20000, T3 = 64'h30000;
   localparam logic [63:0] TS = 64'h40000, TP = 64'h50000;
   localparam logic [63:0] SS = 64'h60000, SP = 64'h70000;
   localparam logic [63:0] HS = 64'h80000, HP = 64'h90000;
   localparam logic [63:0] VA_FULL  = {11'd1, 11'd2, 11'd3, 11'd4, 8'd5, 12'h000};
   localparam logic [63:0] VA_SHORT = {33'd0, 11'd4, 8'd5, 12'h000};
   localparam logic [63:0] ROOT_R1  = T1 | 64'hC;

   // memory responder: one response per handshake, ready withheld every third cycle
   initial begin
      int stall = 0;
      forever begin
         @(posedge clk);
         mem_rsp_valid <= 1'b0;
         if (mem_rd_valid && mem_rd_ready) begin
            rd_count++;
            if (mem.exists(mem_rd_addr)) mem_rsp_data <= mem[mem_rd_addr];
            else begin miss_count++; mem_rsp_data <= '0; end
            mem_rsp_valid <= 1'b1;
         end
         mem_rd_ready <= (stall % 3) != 2;
         stall++;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic walk(input logic [63:0] va, input logic [1:0] kind, input logic [1:0] mode,
                       input bit dat, input bit wide);
      int rd0, miss0, n;
      @(negedge clk);
      rd0 = rd_count; miss0 = miss_count;
      req_va = va; req_kind = kind; req_mode = mode; req_dat_en = dat; req_wide = wide;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R1 ready low after accept", 64'(req_ready), 64'd0);
      n = 0;
      while (!done && n < 2000) begin @(negedge clk); n++; end
      if (!done) chk("R1 done never rose", 64'd0, 64'd1);
      r_addr = rsp_raddr; r_perm = rsp_perm; r_fault = rsp_fault; r_xword = rsp_xword;
      r_reads = rd_count - rd0; r_miss = miss_count - miss0;
      @(negedge clk);
      chk("R1 done single cycle", 64'(done), 64'd0);
      chk("R1 ready back after done", 64'(req_ready), 64'd1);
   endtask

   task automatic expect_ok(input string tag, input logic [63:0] addr, input logic [2:0] perm,
                            input int reads);
      chk({tag, " fault"}, 64'(r_fault), 64'd0);
      chk({tag, " raddr"}, r_addr, addr);
      chk({tag, " perm"}, 64'(r_perm), 64'(perm));
      chk({tag, " reads"}, 64'(r_reads), 64'(reads));
      chk({tag, " unmapped reads"}, 64'(r_miss), 64'd0);
   endtask

   task automatic expect_flt(input string tag, input logic [2:0] code, input logic [63:0] xw,
                             input int reads);
      chk({tag, " fault"}, 64'(r_fault), 64'(code));
      chk({tag, " xword"}, r_xword, xw);
      chk({tag, " perm zero R14"}, 64'(r_perm), 64'd0);
      chk({tag, " raddr zero R14"}, r_addr, 64'd0);
      chk({tag, " reads"}, 64'(r_reads), 64'(reads));
   endtask

   task automatic build_tables();
      mem[T1 + 1*8] = T2 | 64'h8;
      mem[T2 + 2*8] = T3 | 64'h4;
      mem[T3 + 3*8] = TS;
      mem[TS + 4*8] = TP;
      mem[TP + 5*8] = 64'hABCDE0AB;
      mem[SS + 4*8] = SP;
      mem[SP + 5*8] = 64'h12345000;
      mem[HS + 4*8] = HP;
      mem[HP + 5*8] = 64'h77777000;
      root_pri = ROOT_R1; root_sec = SS; root_home = HS;
   endtask

   task automatic t_reset();
      chk("R1 reset ready", 64'(req_ready), 64'd1);
      chk("R1 reset done", 64'(done), 64'd0);
      chk("R1 reset no read", 64'(mem_rd_valid), 64'd0);
   endtask

   task automatic t_dat_off();
      walk(64'h1234_5678_9ABC_DEF0, 2'd0, 2'd1, 1'b0, 1'b1);
      expect_ok("R2 dat off wide", 64'h1234_5678_9ABC_D000, 3'b111, 0);
      walk(64'h3_0000_5000, 2'd2, 2'd2, 1'b0, 1'b0);
      expect_ok("R2 R3 dat off narrow", 64'h5000, 3'b111, 0);
      walk(64'hFFFF_FFFF_8000_1FFF, 2'd1, 2'd1, 1'b0, 1'b0);
      expect_ok("R13 R3 dat off low window", 64'h41000, 3'b111, 0);
   endtask

   task automatic t_range();
      root_pri = SS;
      walk(64'h8000_0000, 2'd0, 2'd1, 1'b1, 1'b1);
      expect_flt("R5 segment root", 3'd3, 64'h8000_0001, 0);
      walk(64'hFFFF_0000_8040_5000, 2'd0, 2'd1, 1'b1, 1'b0);
      expect_ok("R3 narrow passes range", 64'h12345000, 3'b111, 2);
      root_pri = T3 | 64'h4;
      walk(64'h1 << 42, 2'd0, 2'd1, 1'b1, 1'b1);
      expect_flt("R5 region3 root", 3'd3, (64'h1 << 42) | 64'h1, 0);
      root_pri = T2 | 64'h8;
      walk(64'h1 << 53, 2'd0, 2'd1, 1'b1, 1'b1);
      expect_flt("R5 region2 root", 3'd3, (64'h1 << 53) | 64'h1, 0);
      root_pri = ROOT_R1;
   endtask

   task automatic t_full_walk();
      walk(VA_FULL, 2'd0, 2'd1, 1'b1, 1'b1);
      expect_ok("R6 R10 five level walk", 64'hABCDE000, 3'b111, 5);
   endtask

   task automatic t_page_entry();
      mem[TP + 5*8] = 64'hABCDE200;
      walk(VA_FULL, 2'd0, 2'd1, 1'b1, 1'b1);
      expect_ok("R11 read-only read", 64'hABCDE000, 3'b101, 5);
      walk(VA_FULL, 2'd1, 2'd1, 1'b1, 1'b1);
      expect_flt("R11 R14 write to read-only", 3'd4, VA_FULL | 64'h5, 5);
      mem[TP + 5*8] = 64'hABCDE400;
      walk(VA_FULL, 2'd0, 2'd1, 1'b1, 1'b1);
      expect_flt("R10 invalid page entry", 3'd1, VA_FULL | 64'h1, 5);
      mem[TP + 5*8] = 64'hABCDE0AB;
   endtask

   task automatic t_invalid();
      mem[T2 + 2*8] = T3 | 64'h24;
      walk(VA_FULL, 2'd0, 2'd1, 1'b1, 1'b1);
      expect_flt("R7 invalid region entry", 3'd2, VA_FULL | 64'h1, 2);
      mem[T2 + 2*8] = T3 | 64'h4;
      mem[TS + 4*8] = TP | 64'h20;
      walk(VA_FULL, 2'd0, 2'd1, 1'b1, 1'b1);
      expect_flt("R7 invalid segment entry", 3'd2, VA_FULL | 64'h1, 4);
      mem[TS + 4*8] = TP;
      root_pri = ROOT_R1 | 64'h20;
      walk(VA_FULL, 2'd0, 2'd1, 1'b1, 1'b1);
      expect_flt("R7 invalid root", 3'd2, VA_FULL | 64'h1, 0);
      root_pri = ROOT_R1;
   endtask

   task automatic t_type_mismatch();
      mem[T1 + 1*8] = T2 | 64'h4;
      walk(VA_FULL, 2'd0, 2'd1, 1'b1, 1'b1);
      expect_flt("R8 wrong entry type", 3'd3, VA_FULL | 64'h1, 1);
      mem[T1 + 1*8] = T2 | 64'h8;
   endtask

   task automatic t_real_space();
      root_pri = ROOT_R1 | 64'h40;
      walk(VA_FULL, 2'd1, 2'd1, 1'b1, 1'b1);
      expect_ok("R9 real-space root", VA_FULL, 3'b111, 0);
      walk(64'h1000, 2'd0, 2'd1, 1'b1, 1'b1);
      expect_ok("R9 R13 real-space low", 64'h41000, 3'b111, 0);
      root_pri = ROOT_R1;
      root_sec = SS | 64'h40;
      walk(64'h9000, 2'd0, 2'd2, 1'b1, 1'b1);
      expect_ok("R9 R12 real-space secondary", 64'h9000, 3'b110, 0);
      root_sec = SS;
   endtask

   task automatic t_spaces();
      walk(VA_SHORT, 2'd0, 2'd2, 1'b1, 1'b1);
      expect_ok("R4 R12 secondary data", 64'h12345000, 3'b110, 2);
      walk(VA_FULL, 2'd2, 2'd2, 1'b1, 1'b1);
      expect_ok("R12 secondary fetch via primary", 64'hABCDE000, 3'b001, 5);
      mem[SP + 5*8] = 64'h12345200;
      walk(VA_SHORT, 2'd1, 2'd2, 1'b1, 1'b1);
      expect_flt("R12 R14 secondary write protect", 3'd4, VA_SHORT | 64'h6, 2);
      mem[SP + 5*8] = 64'h12345000;
      mem[TP + 5*8] = 64'hABCDE400;
      walk(VA_FULL, 2'd2, 2'd2, 1'b1, 1'b1);
      expect_flt("R12 secondary fetch space code", 3'd1, VA_FULL | 64'h1, 5);
      mem[TP + 5*8] = 64'hABCDE0AB;
      walk(VA_SHORT, 2'd0, 2'd3, 1'b1, 1'b1);
      expect_ok("R4 home walk", 64'h77777000, 3'b111, 2);
      mem[HP + 5*8] = 64'h77777400;
      walk(VA_SHORT, 2'd0, 2'd3, 1'b1, 1'b1);
      expect_flt("R4 R14 home space code", 3'd1, VA_SHORT | 64'h3, 2);
      mem[HP + 5*8] = 64'h77777000;
   endtask

   task automatic t_prefix();
      mem[TP + 5*8] = 64'h1000;
      walk(VA_FULL, 2'd0, 2'd1, 1'b1, 1'b1);
      expect_ok("R13 walked frame below limit", 64'h41000, 3'b111, 5);
      mem[TP + 5*8] = 64'h2000;
      walk(VA_FULL, 2'd0, 2'd1, 1'b1, 1'b1);
      expect_ok("R13 frame at limit", 64'h2000, 3'b111, 5);
      mem[TP + 5*8] = 64'hABCDE0AB;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL R1 watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      build_tables();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_dat_off();
      t_range();
      t_full_walk();
      t_page_entry();
      t_invalid();
      t_type_mismatch();
      t_real_space();
      t_spaces();
      t_prefix();
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule